// File: doc/BRIEF.md
# DMA Request Event Scheduler

This block watches a set of level-type DMA request lines coming from peripherals and converts each rising edge into the activation of one or more channels. Which channels a request line wakes up is set by a request-to-channel matrix that the host programs. Every channel holds a pending flag, set when it is activated, and an error flag, set when a further request edge for it arrives while it is still pending. A mirror of the synchronized request levels is always visible.

A single channel engine serves the pending channels one at a time. For each channel it performs a burst of peripheral word accesses of the programmed watermark size. After the burst it looks at the mirror level of that channel's requests and runs another burst while any of them is still high. This catches work that a late burst would otherwise lose, because a request that stays high produces no new edge. Each word access is a valid/ready handshake on a per-channel strobe. A strobe stays asserted until the peripheral side accepts it, so the peripheral exerts back-pressure by holding ready low. Error flags stall their channel until the host clears them. An interrupt output reports error flags that the host has enabled.

Top module: `dreq_sched`

## Requirements
- R1: `mirror_o[r]` equals the level of `req_i[r]` after two clock edges of synchronization, whether or not the line is mapped to a channel.
- R2: A rising edge on a request line sets the pending flag (`pend_o`) of each mapped channel on the third clock edge after the input changes. A line that stays high does not activate again.
- R3: Bit `map_i[c*NREQ + r]` set means request `r` activates channel `c`. One edge activates every channel whose bit is set, and a request mapped to no channel sets no flag.
- R4: A burst for channel `c` is `wm_i + 1` words. A word moves on each clock edge where `xfer_o[c]` and `xfer_ready_i` are both high. `xfer_o` is at most one-hot and holds steady while ready is low.
- R5: After each burst, if any request mapped to the channel still reads high on `mirror_o`, another full burst follows. Otherwise the channel's work is complete.
- R6: On completion the channel's pending flag clears and `done_o[c]` pulses for one cycle. `done_o[c]` never pulses while a mapped request was high in the decision cycle.
- R7: A request edge that maps to a channel whose pending flag is already set sets that channel's error flag (`err_o`).
- R8: A channel with its error flag set is never started. If its flag sets during a burst, the burst finishes and then the engine stops the channel with its pending flag kept. The channel resumes once the error is cleared.
- R9: A host write with `host_sel_i = 0` clears each error flag whose `host_wdata_i` bit is 1 and leaves the others unchanged. A set in the same cycle wins over the clear.
- R10: A host write with `host_sel_i = 1` loads the interrupt enable mask. `irq_o` is high exactly when some error flag with its mask bit set is high.
- R11: When several channels are pending, the highest-numbered eligible channel is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NREQ | Level DMA request lines from peripherals |
| map_i | input | NCH*NREQ | Request-to-channel matrix, bit c*NREQ+r |
| wm_i | input | WM_W | Watermark: words per burst minus one |
| host_we_i | input | 1 | Host write strobe |
| host_sel_i | input | 1 | 0: clear error bits, 1: load interrupt mask |
| host_wdata_i | input | NCH | Host write data, one bit per channel |
| xfer_o | output | NCH | Per-channel word transfer strobe (valid) |
| xfer_ready_i | input | 1 | Peripheral side accepts the current word |
| done_o | output | NCH | One-cycle channel completion pulse |
| pend_o | output | NCH | Pending flags |
| err_o | output | NCH | Error flags |
| mirror_o | output | NREQ | Synchronized request levels |
| irq_o | output | 1 | Error interrupt |

## Verification
The mirror changes two edges after a request input changes. Pending and error flags change on the third edge. A strobe first appears on the fourth edge, and completion, with its done pulse and pending clear, is due one edge after the last word of the last burst. Host writes take effect on the edge that samples them. The bench drives on falling edges and samples these timed results on the falling edge after the edge where they are due. For the transfer activity, whose length depends on random back-pressure, it counts handshakes and done pulses at each rising edge and compares the totals against burst sizes worked out from the watermark once the block is idle.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_BURST = 2'd1,
    ENG_CHECK = 2'd2
  } eng_state_e;
endpackage

// File: rtl/dreq_sync_edge.sv
module dreq_sync_edge #(
  parameter int NREQ = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req_i,
  output logic [NREQ-1:0] level_o,
  output logic [NREQ-1:0] rise_o
);
  logic [NREQ-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= req_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign level_o = s2_q;
  assign rise_o  = s2_q & ~s3_q;
endmodule

// File: rtl/dreq_chan_flags.sv
module dreq_chan_flags #(
  parameter int NREQ = 4,
  parameter int NCH  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NREQ-1:0]     rise_i,
  input  logic [NCH*NREQ-1:0] map_i,
  input  logic                host_we_i,
  input  logic                host_sel_i,
  input  logic [NCH-1:0]      host_wdata_i,
  input  logic [NCH-1:0]      clr_pend_i,
  output logic [NCH-1:0]      pend_o,
  output logic [NCH-1:0]      err_o,
  output logic [NCH-1:0]      mask_o
);
  logic err_clr_wr;
  assign err_clr_wr = host_we_i && !host_sel_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       mask_o <= '0;
    else if (host_we_i && host_sel_i) mask_o <= host_wdata_i;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = |(rise_i & map_i[c*NREQ +: NREQ]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_o[c] <= 1'b0;
        err_o[c]  <= 1'b0;
      end else begin
        if (err_clr_wr && host_wdata_i[c]) err_o[c] <= 1'b0;
        if (clr_pend_i[c])                 pend_o[c] <= 1'b0;
        if (hit) begin
          if (pend_o[c]) err_o[c]  <= 1'b1;
          else           pend_o[c] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dreq_engine.sv
module dreq_engine
  import dreq_pkg::*;
#(
  parameter int NREQ = 4,
  parameter int NCH  = 4,
  parameter int WM_W = 3,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCH-1:0]      pend_i,
  input  logic [NCH-1:0]      err_i,
  input  logic [NREQ-1:0]     level_i,
  input  logic [NCH*NREQ-1:0] map_i,
  input  logic [WM_W-1:0]     wm_i,
  input  logic                ready_i,
  output logic [NCH-1:0]      xfer_o,
  output logic [NCH-1:0]      clr_pend_o,
  output logic [NCH-1:0]      done_o
);
  eng_state_e      st_q;
  logic [CH_W-1:0] cur_q, pick;
  logic [WM_W-1:0] cnt_q, wm_q;
  logic [NCH-1:0]  elig;
  logic            more, finish;

  assign elig = pend_i & ~err_i;

  // later iterations overwrite earlier ones: highest index wins
  always_comb begin
    pick = '0;
    for (int c = 0; c < NCH; c++)
      if (elig[c]) pick = CH_W'(c);
  end

  assign more   = |(level_i & map_i[cur_q*NREQ +: NREQ]);
  assign finish = (st_q == ENG_CHECK) && !err_i[cur_q] && !more;

  always_comb begin
    xfer_o     = '0;
    clr_pend_o = '0;
    if (st_q == ENG_BURST) xfer_o[cur_q]     = 1'b1;
    if (finish)            clr_pend_o[cur_q] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ENG_IDLE;
      cur_q  <= '0;
      cnt_q  <= '0;
      wm_q   <= '0;
      done_o <= '0;
    end else begin
      done_o <= clr_pend_o;
      unique case (st_q)
        ENG_IDLE: if (|elig) begin
          cur_q <= pick;
          cnt_q <= '0;
          wm_q  <= wm_i;
          st_q  <= ENG_BURST;
        end
        ENG_BURST: if (ready_i) begin
          if (cnt_q == wm_q) st_q  <= ENG_CHECK;
          else               cnt_q <= cnt_q + 1'b1;
        end
        ENG_CHECK: begin
          if (!err_i[cur_q] && more) begin
            cnt_q <= '0;
            wm_q  <= wm_i;
            st_q  <= ENG_BURST;
          end else begin
            st_q  <= ENG_IDLE;
          end
        end
        default: st_q <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dreq_sched.sv
module dreq_sched #(
  parameter int NREQ = 4,
  parameter int NCH  = 4,
  parameter int WM_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NREQ-1:0]     req_i,
  input  logic [NCH*NREQ-1:0] map_i,
  input  logic [WM_W-1:0]     wm_i,
  input  logic                host_we_i,
  input  logic                host_sel_i,
  input  logic [NCH-1:0]      host_wdata_i,
  output logic [NCH-1:0]      xfer_o,
  input  logic                xfer_ready_i,
  output logic [NCH-1:0]      done_o,
  output logic [NCH-1:0]      pend_o,
  output logic [NCH-1:0]      err_o,
  output logic [NREQ-1:0]     mirror_o,
  output logic                irq_o
);
  logic [NREQ-1:0] rise;
  logic [NCH-1:0]  clr_pend, mask;

  dreq_sync_edge #(.NREQ(NREQ)) u_sync (
    .clk(clk), .rst_n(rst_n), .req_i(req_i),
    .level_o(mirror_o), .rise_o(rise)
  );

  dreq_chan_flags #(.NREQ(NREQ), .NCH(NCH)) u_flags (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .map_i(map_i),
    .host_we_i(host_we_i), .host_sel_i(host_sel_i), .host_wdata_i(host_wdata_i),
    .clr_pend_i(clr_pend), .pend_o(pend_o), .err_o(err_o), .mask_o(mask)
  );

  dreq_engine #(.NREQ(NREQ), .NCH(NCH), .WM_W(WM_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_o), .err_i(err_o),
    .level_i(mirror_o), .map_i(map_i), .wm_i(wm_i), .ready_i(xfer_ready_i),
    .xfer_o(xfer_o), .clr_pend_o(clr_pend), .done_o(done_o)
  );

  assign irq_o = |(err_o & mask);
endmodule

// File: rtl/dreq_sched_chk.sv
module dreq_sched_chk #(
  parameter int NREQ = 4,
  parameter int NCH  = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NCH*NREQ-1:0] map_i,
  input logic                host_we_i,
  input logic                host_sel_i,
  input logic [NCH-1:0]      host_wdata_i,
  input logic [NCH-1:0]      xfer_o,
  input logic                xfer_ready_i,
  input logic [NCH-1:0]      done_o,
  input logic [NCH-1:0]      pend_o,
  input logic [NCH-1:0]      err_o,
  input logic [NREQ-1:0]     mirror_o,
  input logic                irq_o
);
  a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(xfer_o));

  a_r4_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (|xfer_o && !xfer_ready_i) |=> (xfer_o == $past(xfer_o)));

  a_r2_xfer_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_o & ~pend_o) == '0);

  a_r7_err_from_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o & ~$past(err_o) & ~$past(pend_o)) == '0);

  a_r10_irq_needs_err: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> |err_o);

  for (genvar c = 0; c < NCH; c++) begin : g_c
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o[c] && !(host_we_i && !host_sel_i && host_wdata_i[c])) |=> err_o[c]);

    a_r6_done_mirror_low: assert property (@(posedge clk) disable iff (!rst_n)
      done_o[c] |-> $past((mirror_o & map_i[c*NREQ +: NREQ]) == '0));
  end
endmodule

bind dreq_sched dreq_sched_chk #(.NREQ(NREQ), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .map_i(map_i), .host_we_i(host_we_i),
  .host_sel_i(host_sel_i), .host_wdata_i(host_wdata_i), .xfer_o(xfer_o),
  .xfer_ready_i(xfer_ready_i), .done_o(done_o), .pend_o(pend_o),
  .err_o(err_o), .mirror_o(mirror_o), .irq_o(irq_o)
);

// File: tb/sim_dreq_sched.sv
module sim_dreq_sched;
  localparam int NREQ = 4;
  localparam int NCH  = 4;
  localparam int WM_W = 3;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [NREQ-1:0]     req_i = '0;
  logic [NCH*NREQ-1:0] map_i = '0;
  logic [WM_W-1:0]     wm_i = '0;
  logic                host_we_i = 1'b0;
  logic                host_sel_i = 1'b0;
  logic [NCH-1:0]      host_wdata_i = '0;
  logic                xfer_ready_i = 1'b0;
  logic [NCH-1:0]      xfer_o, done_o, pend_o, err_o;
  logic [NREQ-1:0]     mirror_o;
  logic                irq_o;

  int total = 0;
  int bad   = 0;
  bit rnd_rdy = 1'b1;
  bit rdy_force = 1'b0;
  bit clr_req = 1'b0;
  int words [NCH];
  int dones [NCH];
  int dseq  [8];
  int dn;

  always #2 clk = ~clk;

  dreq_sched #(.NREQ(NREQ), .NCH(NCH), .WM_W(WM_W)) u0 (.*);

  always @(negedge clk)
    xfer_ready_i <= rnd_rdy ? ($urandom_range(0, 3) != 0) : rdy_force;

  always @(posedge clk) begin
    if (clr_req) begin
      for (int c = 0; c < NCH; c++) begin words[c] = 0; dones[c] = 0; end
      dn = 0;
    end else if (rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        if (xfer_o[c] && xfer_ready_i) words[c]++;
        if (done_o[c]) begin
          dones[c]++;
          if (dn < 8) dseq[dn] = c;
          dn++;
        end
      end
    end
  end

  function automatic int burst_words(input int wm, input int bursts);
    return (wm + 1) * bursts;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_counts();
    clr_req = 1'b1; step(1); clr_req = 1'b0;
  endtask

  task automatic host_wr(input bit sel, input logic [NCH-1:0] d);
    host_we_i = 1'b1; host_sel_i = sel; host_wdata_i = d;
    step(1);
    host_we_i = 1'b0; host_wdata_i = '0;
  endtask

  task automatic pulse(input int r, input int len);
    req_i[r] = 1'b1; step(len); req_i[r] = 1'b0;
  endtask

  task automatic wait_idle();
    step(6);
    for (int i = 0; i < 3000; i++) begin
      if (pend_o == '0 && xfer_o == '0) break;
      step(1);
    end
    step(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5e_a7c3));
    step(3);
    // reset state
    chk("R4 reset xfer", int'(xfer_o), 0);
    chk("R2 reset pend", int'(pend_o), 0);
    chk("R7 reset err", int'(err_o), 0);
    chk("R10 reset irq", int'(irq_o), 0);
    rst_n = 1'b1;
    step(2);
    clear_counts();

    // R1/R2: timing of mirror and pending, single burst of 4 words
    map_i = '0; map_i[0*NREQ + 0] = 1'b1; wm_i = 3'd3;
    req_i[0] = 1'b1;
    step(1); chk("R1 mirror after 1 edge", int'(mirror_o[0]), 0);
    step(1); chk("R1 mirror after 2 edges", int'(mirror_o[0]), 1);
             chk("R2 pend after 2 edges", int'(pend_o[0]), 0);
    step(1); chk("R2 pend after 3 edges", int'(pend_o[0]), 1);
    req_i[0] = 1'b0;
    wait_idle();
    chk("R4 one burst words", words[0], burst_words(3, 1));
    chk("R6 done count", dones[0], 1);
    chk("R6 pend cleared", int'(pend_o), 0);

    // R5: level held past two bursts forces a third, no error from steady level
    clear_counts();
    req_i[0] = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      if (words[0] >= 8) break;
      step(1);
    end
    req_i[0] = 1'b0;
    wait_idle();
    chk("R5 re-check bursts words", words[0], burst_words(3, 3));
    chk("R5 single done", dones[0], 1);
    chk("R2 steady level no error", int'(err_o), 0);

    // R1/R3: unmapped request visible on mirror only
    req_i[3] = 1'b1; step(4);
    chk("R1 mirror unmapped", int'(mirror_o), 8);
    chk("R3 unmapped no pend", int'(pend_o), 0);
    req_i[3] = 1'b0; step(4);

    // R3/R11: one edge to channels 1 and 3, served 3 first
    clear_counts();
    map_i = '0; map_i[1*NREQ + 2] = 1'b1; map_i[3*NREQ + 2] = 1'b1; wm_i = 3'd1;
    pulse(2, 1);
    wait_idle();
    chk("R3 ch3 words", words[3], burst_words(1, 1));
    chk("R3 ch1 words", words[1], burst_words(1, 1));
    chk("R11 first done ch3", dseq[0], 3);
    chk("R11 second done ch1", dseq[1], 1);

    // R7-R10: error on re-trigger while pending
    clear_counts();
    rnd_rdy = 1'b0; rdy_force = 1'b0;
    map_i = '0; map_i[0] = 1'b1; wm_i = 3'd2;
    host_wr(1'b1, 4'b0000);
    pulse(0, 1); step(6);
    chk("R4 valid held while stalled", int'(xfer_o), 1);
    pulse(0, 1); step(4);
    chk("R7 error set", int'(err_o), 1);
    chk("R10 masked no irq", int'(irq_o), 0);
    host_wr(1'b1, 4'b0001);
    chk("R10 enabled irq", int'(irq_o), 1);
    host_wr(1'b0, 4'b0010);
    chk("R9 other bit keeps error", int'(err_o[0]), 1);
    rdy_force = 1'b1;
    step(12);
    chk("R8 burst finished words", words[0], burst_words(2, 1));
    chk("R8 stalled no xfer", int'(xfer_o), 0);
    chk("R8 pend kept", int'(pend_o[0]), 1);
    chk("R8 no done", dones[0], 0);
    host_wr(1'b0, 4'b0001);
    chk("R9 error cleared", int'(err_o), 0);
    chk("R10 irq dropped", int'(irq_o), 0);
    wait_idle();
    chk("R8 resumed words", words[0], burst_words(2, 2));
    chk("R8 resumed done", dones[0], 1);
    host_wr(1'b1, 4'b0000);
    rnd_rdy = 1'b1;

    // random mapping, watermark and pulse length
    for (int it = 0; it < 24; it++) begin
      int r, wm;
      logic [NCH-1:0] chs;
      int prev;
      bit ord_ok;
      r   = $urandom_range(0, NREQ - 1);
      chs = NCH'($urandom_range(1, 15));
      wm  = $urandom_range(1, 7);
      map_i = '0;
      for (int c = 0; c < NCH; c++) map_i[c*NREQ + r] = chs[c];
      wm_i = WM_W'(wm);
      clear_counts();
      pulse(r, $urandom_range(1, 3));
      wait_idle();
      for (int c = 0; c < NCH; c++)
        chk("R3 random words", words[c], chs[c] ? burst_words(wm, 1) : 0);
      chk("R6 random dones", dn, $countones(chs));
      chk("R7 random no error", int'(err_o), 0);
      ord_ok = 1'b1; prev = NCH;
      for (int k = 0; k < dn && k < 8; k++) begin
        if (dseq[k] >= prev) ord_ok = 1'b0;
        prev = dseq[k];
      end
      chk("R11 random order descending", int'(ord_ok), 1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule